// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns sixteen external signal lines into interrupt requests. Each line takes its input from one pin position of one of up to sixteen GPIO ports. A per-line selector picks the port. The chosen input is resynchronised to the block clock, and a per-line rising enable and a per-line falling enable decide which transitions latch that line's pending flag. Software may also latch a pending flag directly, without any input activity.

A per-line enable mask gates the pending flags before they are folded onto seven request outputs. The five lowest lines each drive a dedicated output. The next five lines share one output, and the top six lines share the last one. Configuration, pending status and software triggering are reached over a simple register bus. The bus uses byte addresses and 32-bit data, and its read data is combinational from the address.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Line n takes pin n of the port named by its 4-bit select field. The field for line n is held in the select word at byte address 4*(n/4), in bits (n%4)*4+3 down to (n%4)*4. Pin n of port p is `portPins[p*16+n]`. Bits 31:16 of a select word read as zero.
- R2: The rising-enable word at byte address 0x10 has bit n for line n. When the bit is set, a 0-to-1 change on the line's input sets its pending flag. When it is clear, rising changes do nothing.
- R3: The falling-enable word at 0x14 has bit n for line n. When the bit is set, a 1-to-0 change sets the pending flag. With both enables set, either change sets it.
- R4: The pending word at 0x1C reads the flags. Writing 1 to bit n clears flag n, and writing 0 leaves it as it was.
- R5: Writing 1 to bit n of the software-trigger word at 0x20 sets flag n one clock later. That word always reads as zero.
- R6: The mask word at 0x18 uses 1 to mean enabled. A pending line with mask bit 0 drives no request output.
- R7: `irqOut[k]` for k=0..4 is (pending[k] AND mask[k]). `irqOut[5]` is the OR of the enabled pending lines 5..9, and `irqOut[6]` is the OR of the enabled pending lines 10..15.
- R8: An input change presented before clock edge k shows on the pending flag and the request output just after edge k+2. Two edges go to synchronisation and one to latching.
- R9: When an enabled edge and a pending clear for the same line land on the same clock edge, the flag ends set.
- R10: While `rstN` is low, every pending flag, enable, mask and select field is zero, and all request outputs are low.
- R11: Writes to byte addresses other than 0x00–0x20 change nothing, and reads of them return zero. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portPins | input | 256 | All port pins; bit p*16+n is pin n of port p |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| irqOut | output | 7 | Grouped interrupt requests |

## Verification
The hardest case to reach from the ports is the collision in R9. A clear must be on the bus exactly at the edge where a synchronised input transition is latched. The bench drives the pin on a falling clock edge and lets two rising edges pass through the synchroniser. It then places the clear write so that it is sampled on the third rising edge. The flag is first preset by a software trigger, so a lost edge would show up as a cleared flag. A behavioural model, advanced on every clock, also follows a long pseudo-random phase in which pin toggles, port reselection and clears overlap freely.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int LINE_CNT = 16;
  localparam int FIELD_STRIDE = 4;
  localparam int FIELDS_PER_WORD = 4;

  // word indexes (byte address / 4)
  localparam logic [5:0] W_RISE = 6'd4;
  localparam logic [5:0] W_FALL = 6'd5;
  localparam logic [5:0] W_MASK = 6'd6;
  localparam logic [5:0] W_PEND = 6'd7;
  localparam logic [5:0] W_SOFT = 6'd8;

  typedef struct packed {
    logic [LINE_CNT-1:0] clrPend;
    logic [LINE_CNT-1:0] setSoft;
  } strobes_t;
endpackage

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int NUM_LINES = LINE_CNT,
  parameter int SEL_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busSel,
  input  logic                       busWrite,
  input  logic [7:0]                 busAddr,
  input  logic [31:0]                busWdata,
  output logic [31:0]                busRdata,
  input  logic [NUM_LINES-1:0]       pendQ,
  output strobes_t                   strb,
  output logic [NUM_LINES-1:0]       riseQ,
  output logic [NUM_LINES-1:0]       fallQ,
  output logic [NUM_LINES-1:0]       maskQ,
  output logic [NUM_LINES*SEL_W-1:0] selFlat
);
  localparam int SEL_WORDS = NUM_LINES / FIELDS_PER_WORD;

  logic [5:0] wordIdx;
  logic wrHit;
  logic [SEL_WORDS-1:0] selWrEn;
  logic unusedBits;

  assign wordIdx = busAddr[7:2];
  assign wrHit = busSel & busWrite;
  assign unusedBits = ^{busAddr[1:0], busWdata[31:NUM_LINES]};

  always_comb begin
    strb.setSoft = '0;
    strb.clrPend = '0;
    if (wrHit && wordIdx == W_SOFT) strb.setSoft = busWdata[NUM_LINES-1:0];
    if (wrHit && wordIdx == W_PEND) strb.clrPend = busWdata[NUM_LINES-1:0];
  end

  genvar k;
  generate
    for (k = 0; k < SEL_WORDS; k++) begin : g_selDec
      assign selWrEn[k] = wrHit && (wordIdx == 6'(k));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseQ   <= '0;
      fallQ   <= '0;
      maskQ   <= '0;
      selFlat <= '0;
    end else begin
      if (wrHit && wordIdx == W_RISE) riseQ <= busWdata[NUM_LINES-1:0];
      if (wrHit && wordIdx == W_FALL) fallQ <= busWdata[NUM_LINES-1:0];
      if (wrHit && wordIdx == W_MASK) maskQ <= busWdata[NUM_LINES-1:0];
      for (int w = 0; w < SEL_WORDS; w++) begin
        if (selWrEn[w]) begin
          for (int f = 0; f < FIELDS_PER_WORD; f++) begin
            selFlat[(w*FIELDS_PER_WORD+f)*SEL_W +: SEL_W] <= busWdata[f*FIELD_STRIDE +: SEL_W];
          end
        end
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (wordIdx)
      W_RISE: busRdata[NUM_LINES-1:0] = riseQ;
      W_FALL: busRdata[NUM_LINES-1:0] = fallQ;
      W_MASK: busRdata[NUM_LINES-1:0] = maskQ;
      W_PEND: busRdata[NUM_LINES-1:0] = pendQ;
      default: begin
        for (int w = 0; w < SEL_WORDS; w++) begin
          if (wordIdx == 6'(w)) begin
            for (int f = 0; f < FIELDS_PER_WORD; f++) begin
              busRdata[f*FIELD_STRIDE +: SEL_W] = selFlat[(w*FIELDS_PER_WORD+f)*SEL_W +: SEL_W];
            end
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/edge_irq_datapath.sv
module edge_irq_datapath
  import edge_irq_pkg::*;
#(
  parameter int NUM_LINES = LINE_CNT,
  parameter int NUM_PORTS = 16,
  parameter int SEL_W = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_PORTS*NUM_LINES-1:0] portPins,
  input  logic [NUM_LINES*SEL_W-1:0]     selFlat,
  input  logic [NUM_LINES-1:0]           riseQ,
  input  logic [NUM_LINES-1:0]           fallQ,
  input  logic [NUM_LINES-1:0]           maskQ,
  input  strobes_t                       strb,
  output logic [NUM_LINES-1:0]           pendQ,
  output logic [NUM_LINES-1:0]           edgeVec,
  output logic [NUM_LINES-1:0]           lineAct
);
  localparam int SEL_SPAN = 2 ** SEL_W;

  logic [NUM_LINES-1:0] muxIn;
  logic [NUM_LINES-1:0] syncA;
  logic [NUM_LINES-1:0] syncB;
  logic [NUM_LINES-1:0] prevQ;

  genvar n;
  generate
    for (n = 0; n < NUM_LINES; n++) begin : g_line
      logic [NUM_PORTS-1:0] column;
      logic [SEL_W-1:0] selField;
      assign selField = selFlat[n*SEL_W +: SEL_W];
      always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) column[p] = portPins[p*NUM_LINES + n];
      end
      if (NUM_PORTS == SEL_SPAN) begin : g_full
        assign muxIn[n] = column[selField];
      end else begin : g_pad
        logic [SEL_SPAN-1:0] padded;
        assign padded = {{(SEL_SPAN-NUM_PORTS){1'b0}}, column};
        assign muxIn[n] = padded[selField];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= muxIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  assign edgeVec = (syncB & ~prevQ & riseQ) | (~syncB & prevQ & fallQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else pendQ <= (pendQ & ~strb.clrPend) | edgeVec | strb.setSoft;
  end

  assign lineAct = pendQ & maskQ;
endmodule

// File: rtl/edge_irq_group.sv
module edge_irq_group #(
  parameter int NUM_LINES = 16,
  parameter int NUM_SOLO = 5,
  parameter int MID_LAST = 9
) (
  input  logic [NUM_LINES-1:0]  lineAct,
  output logic [NUM_SOLO+1:0]   irqOut
);
  genvar g;
  generate
    for (g = 0; g < NUM_SOLO; g++) begin : g_solo
      assign irqOut[g] = lineAct[g];
    end
  endgenerate
  assign irqOut[NUM_SOLO]   = |lineAct[MID_LAST:NUM_SOLO];
  assign irqOut[NUM_SOLO+1] = |lineAct[NUM_LINES-1:MID_LAST+1];
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NUM_LINES = LINE_CNT,
  parameter int NUM_PORTS = 16,
  parameter int SEL_W = 4,
  parameter int NUM_SOLO = 5,
  parameter int MID_LAST = 9,
  localparam int NUM_IRQ = NUM_SOLO + 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_PORTS*NUM_LINES-1:0] portPins,
  input  logic                           busSel,
  input  logic                           busWrite,
  input  logic [7:0]                     busAddr,
  input  logic [31:0]                    busWdata,
  output logic [31:0]                    busRdata,
  output logic [NUM_IRQ-1:0]             irqOut
);
  strobes_t strb;
  logic [NUM_LINES-1:0] riseQ, fallQ, maskQ, pendQ, edgeVec, lineAct;
  logic [NUM_LINES*SEL_W-1:0] selFlat;

  edge_irq_regs #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) regsI (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pendQ(pendQ), .strb(strb), .riseQ(riseQ), .fallQ(fallQ),
    .maskQ(maskQ), .selFlat(selFlat)
  );

  edge_irq_datapath #(.NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) dpI (
    .clk(clk), .rstN(rstN), .portPins(portPins), .selFlat(selFlat),
    .riseQ(riseQ), .fallQ(fallQ), .maskQ(maskQ), .strb(strb),
    .pendQ(pendQ), .edgeVec(edgeVec), .lineAct(lineAct)
  );

  edge_irq_group #(.NUM_LINES(NUM_LINES), .NUM_SOLO(NUM_SOLO), .MID_LAST(MID_LAST)) grpI (
    .lineAct(lineAct), .irqOut(irqOut)
  );
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk
  import edge_irq_pkg::*;
#(
  parameter int NUM_LINES = LINE_CNT,
  parameter int NUM_IRQ = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input strobes_t             strb,
  input logic [NUM_LINES-1:0] pendQ,
  input logic [NUM_LINES-1:0] maskQ,
  input logic [NUM_LINES-1:0] edgeVec,
  input logic [NUM_IRQ-1:0]   irqOut
);
  // R6
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & maskQ) == '0) |-> (irqOut == '0));

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(pendQ) & ~$past(strb.clrPend) & ~pendQ) == '0));

  // R5
  soft_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setSoft != '0) |=> ((pendQ & $past(strb.setSoft)) == $past(strb.setSoft)));

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgeVec != '0) |=> ((pendQ & $past(edgeVec)) == $past(edgeVec)));

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(edgeVec) & ~$past(strb.setSoft)) == '0));
endmodule

bind edge_irq_ctrl edge_irq_chk #(.NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ)) chkI (
  .clk(clk), .rstN(rstN), .strb(strb), .pendQ(pendQ), .maskQ(maskQ),
  .edgeVec(edgeVec), .irqOut(irqOut)
);

// File: tb/edge_irq_ctrl_test.sv
`timescale 1ns/1ps
module edge_irq_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [255:0] portPins = '0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [6:0] irqOut;

  int total = 0, failed = 0;
  bit finished = 0;

  edge_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .portPins(portPins), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  logic [15:0] mS1, mS2, mPrev, mPend, mRise, mFall, mMask, mEdge, mNext;
  logic [3:0] mSel [16];

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mPrev = 0; mPend = 0; mRise = 0; mFall = 0; mMask = 0;
      for (int i = 0; i < 16; i++) mSel[i] = 0;
    end else begin
      for (int i = 0; i < 16; i++)
        mEdge[i] = (mS2[i] & ~mPrev[i] & mRise[i]) | (~mS2[i] & mPrev[i] & mFall[i]);
      mNext = mPend;
      if (busSel && busWrite && busAddr[7:2] == 7) mNext = mNext & ~busWdata[15:0];
      mNext = mNext | mEdge;
      if (busSel && busWrite && busAddr[7:2] == 8) mNext = mNext | busWdata[15:0];
      mPrev = mS2; mS2 = mS1;
      for (int i = 0; i < 16; i++) mS1[i] = portPins[int'(mSel[i])*16 + i];
      if (busSel && busWrite) begin
        case (busAddr[7:2])
          0, 1, 2, 3: for (int f = 0; f < 4; f++) mSel[int'(busAddr[7:2])*4+f] = busWdata[f*4 +: 4];
          4: mRise = busWdata[15:0];
          5: mFall = busWdata[15:0];
          6: mMask = busWdata[15:0];
          default: ;
        endcase
      end
      mPend = mNext;
    end
  end

  function automatic logic [6:0] expIrq();
    logic [15:0] a = mPend & mMask;
    return {|a[15:10], |a[9:5], a[4:0]};
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    logic [31:0] r = 0;
    case (a[7:2])
      0, 1, 2, 3: for (int f = 0; f < 4; f++) r[f*4 +: 4] = mSel[int'(a[7:2])*4+f];
      4: r = {16'h0, mRise};
      5: r = {16'h0, mFall};
      6: r = {16'h0, mMask};
      7: r = {16'h0, mPend};
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the request outputs against the model (R7, R8)
  always @(posedge clk) begin
    #5;
    if (!finished) chk("R7 per-cycle irqOut", {25'h0, irqOut}, {25'h0, expIrq()});
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] lit);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #2;
    chk(tag, busRdata, lit);
    chk({tag, " model"}, busRdata, expRead(a));
    busSel = 0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish();
    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    #4000000;
    total++; failed++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2468;
    waitCyc(3);
    #2;
    chk("R10 irq in reset", {25'h0, irqOut}, 0);
    rstN = 1;
    for (int a = 0; a <= 8; a++) rd("R10 reset value", 8'(a*4), 0);

    // R8 latency and R2 rising edge on line 0
    wr(8'h18, 32'hFFFF);
    wr(8'h10, 32'h0001);
    @(negedge clk); portPins[0] = 1;
    @(posedge clk); #5 chk("R8 after edge 1", {25'h0, irqOut}, 0);
    @(posedge clk); #5 chk("R8 after edge 2", {25'h0, irqOut}, 0);
    @(posedge clk); #5 chk("R8 after edge 3", {25'h0, irqOut}, 1);

    // R3 both edges, then falling only
    wr(8'h14, 32'h0001);
    wr(8'h1C, 32'h0001);
    rd("R4 cleared", 8'h1C, 0);
    @(negedge clk); portPins[0] = 0;
    waitCyc(4);
    rd("R3 falling with both", 8'h1C, 1);
    wr(8'h1C, 32'h0001);
    wr(8'h10, 32'h0000);
    @(negedge clk); portPins[0] = 1;
    waitCyc(4);
    rd("R2 rising disabled", 8'h1C, 0);
    @(negedge clk); portPins[0] = 0;
    waitCyc(4);
    rd("R3 falling only", 8'h1C, 1);

    // R4 write-zero keeps, write-one clears
    wr(8'h1C, 32'hFFFE);
    rd("R4 write zero no effect", 8'h1C, 1);
    wr(8'h1C, 32'h0001);
    rd("R4 write one clears", 8'h1C, 0);

    // R5 software trigger
    wr(8'h20, 32'h0421);
    rd("R5 soft sets", 8'h1C, 32'h0421);
    rd("R5 soft reads zero", 8'h20, 0);
    @(negedge clk); chk("R7 grouped soft", {25'h0, irqOut}, 32'h61);

    // R6 mask
    wr(8'h18, 32'h0020);
    @(negedge clk); chk("R6 mask gates", {25'h0, irqOut}, 32'h20);
    wr(8'h18, 32'h0000);
    @(negedge clk); chk("R6 all masked", {25'h0, irqOut}, 0);
    rd("R6 pending kept", 8'h1C, 32'h0421);
    wr(8'h18, 32'hFFFF);
    wr(8'h1C, 32'hFFFF);

    // R7 grouping per line
    for (int n = 0; n < 16; n++) begin
      wr(8'h20, 32'(1) << n);
      @(negedge clk);
      chk($sformatf("R7 line %0d", n), {25'h0, irqOut},
          n < 5 ? (32'(1) << n) : (n < 10 ? 32'h20 : 32'h40));
      wr(8'h1C, 32'hFFFF);
    end

    // R1 port select: line 3 -> port 5, line 13 -> port 10
    wr(8'h10, 32'hFFFF);
    wr(8'h14, 32'h0000);
    wr(8'h00, 32'h0000_5000);
    wr(8'h0C, 32'h0000_00A0);
    rd("R1 select word 0", 8'h00, 32'h5000);
    rd("R1 select word 3", 8'h0C, 32'h00A0);
    @(negedge clk); portPins[0*16+3] = 1; portPins[0*16+13] = 1;
    waitCyc(4);
    rd("R1 unselected port", 8'h1C, 0);
    @(negedge clk); portPins[5*16+3] = 1;
    waitCyc(4);
    rd("R1 line 3 from port 5", 8'h1C, 32'h0008);
    @(negedge clk); portPins[10*16+13] = 1;
    waitCyc(4);
    rd("R1 line 13 from port 10", 8'h1C, 32'h2008);
    wr(8'h1C, 32'hFFFF);

    // R9 edge and clear on the same clock edge (line 2, port 0)
    wr(8'h10, 32'h0004);
    wr(8'h20, 32'h0004);
    @(negedge clk); portPins[2] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); busSel = 1; busWrite = 1; busAddr = 8'h1C; busWdata = 32'h0004;
    @(negedge clk); busSel = 0; busWrite = 0;
    rd("R9 edge wins over clear", 8'h1C, 32'h0004);
    wr(8'h1C, 32'h0004);
    rd("R9 plain clear", 8'h1C, 0);

    // R11 unmapped address
    wr(8'h3C, 32'hFFFF_FFFF);
    rd("R11 unmapped reads zero", 8'h3C, 0);
    rd("R11 rise unchanged", 8'h10, 32'h0004);
    rd("R11 pending unchanged", 8'h1C, 0);

    // pseudo-random phase, model compared every clock
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      for (int i = 0; i < 8; i++) portPins[i*32 +: 32] = lfsr ^ (32'h9E37_79B9 * i);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      busSel = (lfsr[3:0] == 0);
      busWrite = 1;
      busAddr = {2'b00, 4'(lfsr[11:8] % 9), 2'b00};
      busWdata = {lfsr[7:0], lfsr[31:8]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    end
    @(negedge clk); busSel = 0; busWrite = 0;
    for (int a = 0; a <= 8; a++) rd("R4 random readback", 8'(a*4), expRead(8'(a*4)));

    waitCyc(2);
    finish();
  end
endmodule